// File: doc/BRIEF.md
# Planar Crop Corner Offset Generator

This unit turns the geometry of a planar YUV frame and a crop rectangle inside it into byte offsets for the luma plane and the two chroma planes. It works out those offsets for all four corners of the rectangle. It then picks the corner where a rotated or mirrored copy starts drawing and presents that corner's luma, Cb and Cr offsets.

A request is raised with a one-cycle `start` while the unit is idle. The frame and crop inputs are captured on that edge. The unit runs a fixed sequence of products and quotients through one shift-add multiplier and one restoring divider. When the sequence ends, it raises `done` for one cycle, and the three offsets stay on the outputs until the next request completes.

Chroma subsampling is restricted to a divisor of 1 or 2 in each direction, given as a shift. All arithmetic is unsigned modulo 2^32. Frame width and the chroma plane factor must be non-zero.

Top module: `frame_corner_addr`

## Requirements
- R1: After reset, `busy` and `done` are 0 and all three offset outputs are 0.
- R2: Bytes per pixel is bpp = stride / width, truncated. The top-left luma offset is y*stride + x*bpp.
- R3: The chroma stride is cs = stride >> hshift. The top-left Cb offset is width*height + (y >> vshift)*cs + (x >> hshift).
- R4: The Cr offset of any corner equals the Cb offset of the same corner plus (width*height) / plane_div, truncated.
- R5: A bottom corner adds (h-1)*stride to the luma offset and ((h >> vshift) - 1)*cs to both chroma offsets, modulo 2^32.
- R6: A right corner adds (w-1)*bpp to the luma offset and (w >> hshift) - 1 to both chroma offsets, modulo 2^32.
- R7: The output corner depends on rotation code r (0=0°, 1=90°, 2=180°, 3=270°) and mirror index m, where bit 0 is the X mirror (vertical flip) and bit 1 is the Y mirror (horizontal flip). Each row below gives the corners for m = 0, 1, 2, 3:
  - r=0: TL, TR, BL, BR
  - r=1: TR, TL, BR, BL
  - r=2: BR, BL, TR, TL
  - r=3: BL, BR, TL, TR
- R8: `done` is high for exactly one cycle per request. The offset outputs change only in that cycle and then hold their values.
- R9: A `start` raised while `busy` is high has no effect. The running request completes with the inputs captured when it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, accepted only when idle |
| frm_stride | input | DIM_W | Luma line pitch in bytes |
| frm_width | input | DIM_W | Frame width in pixels (non-zero) |
| frm_height | input | DIM_W | Frame height in lines |
| chroma_hshift | input | 1 | Horizontal chroma divisor as a shift (0 means /1, 1 means /2) |
| chroma_vshift | input | 1 | Vertical chroma divisor as a shift |
| plane_div | input | PDIV_W | Divisor of the luma area that gives the chroma plane size (non-zero) |
| crop_x | input | DIM_W | Crop left edge |
| crop_y | input | DIM_W | Crop top edge |
| crop_w | input | DIM_W | Crop width |
| crop_h | input | DIM_W | Crop height |
| rot_code | input | 2 | Rotation code |
| mirror | input | 2 | Mirror index (bit 0 X mirror, bit 1 Y mirror) |
| busy | output | 1 | A request is running |
| done | output | 1 | One-cycle completion pulse |
| luma_off | output | OFF_W | Luma offset of the start corner |
| cb_off | output | OFF_W | Cb offset of the start corner |
| cr_off | output | OFF_W | Cr offset of the start corner |

## Verification
The results are stored in internal slots before they are combined, so a slot written from the wrong step, or a wrong start-corner decode, shows up as a wrong value on one of the three offsets in the same `done` cycle. All sixteen rotation and mirror pairs are therefore compared against an independent table. A sequencer that skips or repeats a step would change both the offset values and the time `done` arrives. A capture that accepted a second `start` would show up as offsets computed from the later operands.

// File: rtl/fca_pkg.sv
// Shared types for the planar crop corner offset generator.
// Assumes: rotation codes 0..3, mirror index bit 0 = X mirror, bit 1 = Y mirror.
package fca_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_FINAL = 2'd3
    } fca_state_e;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } fca_op_e;

    // Start corner as {bottom, right}. Rotations of 90 and 180 degrees
    // invert the right/left choice, and rotations of 180 and 270 degrees
    // invert the top/bottom choice.
    function automatic logic [1:0] start_corner(input logic [1:0] rot,
                                                input logic [1:0] mir);
        logic right;
        logic bottom;
        right  = mir[0] ^ (rot[0] ^ rot[1]);
        bottom = mir[1] ^ rot[1];
        return {bottom, right};
    endfunction

endpackage

// File: rtl/fca_multiplier.sv
// Sequential shift-add multiplier: one multiplier bit per cycle, B_W cycles.
// Assumes: a and b are held stable from go until done; the product is kept
// modulo 2^A_W. done pulses for one cycle with prod valid.
module fca_multiplier #(
    parameter int A_W = 32,
    parameter int B_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    output logic           done,
    output logic [A_W-1:0] prod
);
    localparam int CNT_W = $clog2(B_W + 1);

    logic [A_W-1:0]   acc_q;
    logic [A_W-1:0]   a_sh_q;
    logic [B_W-1:0]   b_sh_q;
    logic [CNT_W-1:0] cnt_q;
    logic             active_q;

    // Accumulate one partial product per cycle while active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            a_sh_q   <= '0;
            b_sh_q   <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go && !active_q) begin
                acc_q    <= '0;
                a_sh_q   <= a;
                b_sh_q   <= b;
                cnt_q    <= CNT_W'(B_W);
                active_q <= 1'b1;
            end else if (active_q) begin
                if (b_sh_q[0]) begin
                    acc_q <= acc_q + a_sh_q;
                end
                a_sh_q <= a_sh_q << 1;
                b_sh_q <= b_sh_q >> 1;
                cnt_q  <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    active_q <= 1'b0;
                    done     <= 1'b1;
                end
            end
        end
    end

    assign prod = acc_q;

    // The iteration counter never runs out while the unit is still active.
    p_mul_count_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (cnt_q != '0));

    // A result is announced only after an active iteration.
    p_mul_done_after_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(active_q));
endmodule

// File: rtl/fca_divider.sv
// Sequential restoring divider: one quotient bit per cycle, NUM_W cycles.
// Assumes: den is non-zero, and num and den are held from go until done.
// done pulses for one cycle with quot valid.
module fca_divider #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem_q;
    logic [NUM_W-1:0] q_q;
    logic [CNT_W-1:0] cnt_q;
    logic             active_q;
    logic [DEN_W:0]   trial;
    logic             fits;

    // Trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        trial = {rem_q, q_q[NUM_W-1]};
        fits  = (trial >= {1'b0, den});
    end

    // Shift in one dividend bit per cycle and record a quotient bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q    <= '0;
            q_q      <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go && !active_q) begin
                rem_q    <= '0;
                q_q      <= num;
                cnt_q    <= CNT_W'(NUM_W);
                active_q <= 1'b1;
            end else if (active_q) begin
                if (fits) begin
                    rem_q <= DEN_W'(trial - {1'b0, den});
                end else begin
                    rem_q <= trial[DEN_W-1:0];
                end
                q_q   <= {q_q[NUM_W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    active_q <= 1'b0;
                    done     <= 1'b1;
                end
            end
        end
    end

    assign quot = q_q;

    // The partial remainder stays below a non-zero divisor.
    p_div_rem_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && den != '0) |-> (rem_q < den));

    // The iteration counter never runs out while the unit is still active.
    p_div_count_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (cnt_q != '0));
endmodule

// File: rtl/fca_start_corner.sv
// Decodes the rotation code and mirror index into the start corner.
// Assumes the packed mirror index, with bit 0 for the X mirror.
module fca_start_corner (
    input  logic [1:0] rot,
    input  logic [1:0] mir,
    output logic       at_right,
    output logic       at_bottom
);
    import fca_pkg::*;

    // Look up the start corner for this rotation and mirror pair.
    always_comb begin
        {at_bottom, at_right} = start_corner(rot, mir);
    end
endmodule

// File: rtl/frame_corner_addr.sv
// Planar crop corner offset generator (top).
// Captures the frame geometry and crop rectangle on start, then runs nine
// arithmetic steps through one shared multiplier and one shared divider.
// The steps compute bpp, area, chroma plane size, and the top-left and edge
// terms. The last step adds the terms of the selected start corner.
// Assumes: frm_width != 0, plane_div != 0, and shifts of 0 or 1.
module frame_corner_addr #(
    parameter int DIM_W  = 16,
    parameter int OFF_W  = 32,
    parameter int PDIV_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIM_W-1:0]  frm_stride,
    input  logic [DIM_W-1:0]  frm_width,
    input  logic [DIM_W-1:0]  frm_height,
    input  logic              chroma_hshift,
    input  logic              chroma_vshift,
    input  logic [PDIV_W-1:0] plane_div,
    input  logic [DIM_W-1:0]  crop_x,
    input  logic [DIM_W-1:0]  crop_y,
    input  logic [DIM_W-1:0]  crop_w,
    input  logic [DIM_W-1:0]  crop_h,
    input  logic [1:0]        rot_code,
    input  logic [1:0]        mirror,
    output logic              busy,
    output logic              done,
    output logic [OFF_W-1:0]  luma_off,
    output logic [OFF_W-1:0]  cb_off,
    output logic [OFF_W-1:0]  cr_off
);
    import fca_pkg::*;

    localparam int NSTEP  = 9;
    localparam int STEP_W = $clog2(NSTEP);
    // Result slots by step.
    localparam int S_BPP  = 0;  // stride / width
    localparam int S_AREA = 1;  // width * height
    localparam int S_PLN  = 2;  // area / plane_div
    localparam int S_YST  = 3;  // y * stride
    localparam int S_XB   = 4;  // x * bpp
    localparam int S_YC   = 5;  // (y >> v) * cs
    localparam int S_HL   = 6;  // (h - 1) * stride
    localparam int S_HC   = 7;  // ((h >> v) - 1) * cs
    localparam int S_WL   = 8;  // (w - 1) * bpp

    fca_state_e          state_q;
    logic [STEP_W-1:0]   step_q;
    logic [OFF_W-1:0]    res_q [NSTEP];

    logic [DIM_W-1:0]    stride_q, width_q, height_q;
    logic [DIM_W-1:0]    x_q, y_q, w_q, h_q;
    logic [PDIV_W-1:0]   pdiv_q;
    logic                hsh_q, vsh_q;
    logic [1:0]          rot_q, mir_q;

    fca_op_e             op_kind;
    logic [OFF_W-1:0]    op_a;
    logic [DIM_W-1:0]    op_b;
    logic                mul_go, div_go, mul_done, div_done, unit_done;
    logic [OFF_W-1:0]    mul_prod, div_quot, unit_res;
    logic                at_right, at_bottom;

    logic [DIM_W-1:0]    cstride;
    logic [OFF_W-1:0]    tl_y, tl_u, tl_v, wc, add_y, add_c;

    // Chroma stride derived from the luma stride and horizontal divisor.
    always_comb cstride = stride_q >> hsh_q;

    // Choose the unit and operands for the current step.
    always_comb begin
        op_kind = OP_MUL;
        op_a    = '0;
        op_b    = '0;
        case (step_q)
            STEP_W'(S_BPP): begin
                op_kind = OP_DIV;
                op_a    = OFF_W'(stride_q);
                op_b    = width_q;
            end
            STEP_W'(S_AREA): begin
                op_a = OFF_W'(width_q);
                op_b = height_q;
            end
            STEP_W'(S_PLN): begin
                op_kind = OP_DIV;
                op_a    = res_q[S_AREA];
                op_b    = DIM_W'(pdiv_q);
            end
            STEP_W'(S_YST): begin
                op_a = OFF_W'(y_q);
                op_b = stride_q;
            end
            STEP_W'(S_XB): begin
                op_a = OFF_W'(x_q);
                op_b = res_q[S_BPP][DIM_W-1:0];
            end
            STEP_W'(S_YC): begin
                op_a = OFF_W'(y_q >> vsh_q);
                op_b = cstride;
            end
            STEP_W'(S_HL): begin
                op_a = OFF_W'(h_q) - OFF_W'(1);
                op_b = stride_q;
            end
            STEP_W'(S_HC): begin
                op_a = OFF_W'(h_q >> vsh_q) - OFF_W'(1);
                op_b = cstride;
            end
            default: begin
                op_a = OFF_W'(w_q) - OFF_W'(1);
                op_b = res_q[S_BPP][DIM_W-1:0];
            end
        endcase
    end

    // Launch pulses and completion for the selected arithmetic unit.
    always_comb begin
        mul_go    = (state_q == ST_ISSUE) && (op_kind == OP_MUL);
        div_go    = (state_q == ST_ISSUE) && (op_kind == OP_DIV);
        unit_done = (op_kind == OP_MUL) ? mul_done : div_done;
        unit_res  = (op_kind == OP_MUL) ? mul_prod : div_quot;
    end

    fca_multiplier #(.A_W(OFF_W), .B_W(DIM_W)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (mul_go),
        .a     (op_a),
        .b     (op_b),
        .done  (mul_done),
        .prod  (mul_prod)
    );

    fca_divider #(.NUM_W(OFF_W), .DEN_W(DIM_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (op_a),
        .den   (op_b),
        .done  (div_done),
        .quot  (div_quot)
    );

    fca_start_corner u_corner (
        .rot       (rot_q),
        .mir       (mir_q),
        .at_right  (at_right),
        .at_bottom (at_bottom)
    );

    // Combine the stored terms into the start corner's offsets.
    always_comb begin
        tl_y  = res_q[S_YST] + res_q[S_XB];
        tl_u  = res_q[S_AREA] + res_q[S_YC] + OFF_W'(x_q >> hsh_q);
        tl_v  = tl_u + res_q[S_PLN];
        wc    = OFF_W'(w_q >> hsh_q) - OFF_W'(1);
        add_y = (at_bottom ? res_q[S_HL] : '0) + (at_right ? res_q[S_WL] : '0);
        add_c = (at_bottom ? res_q[S_HC] : '0) + (at_right ? wc : '0);
    end

    // Sequencer: capture, issue each step, store results, publish outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            step_q   <= '0;
            done     <= 1'b0;
            luma_off <= '0;
            cb_off   <= '0;
            cr_off   <= '0;
            stride_q <= '0;
            width_q  <= '0;
            height_q <= '0;
            x_q      <= '0;
            y_q      <= '0;
            w_q      <= '0;
            h_q      <= '0;
            pdiv_q   <= '0;
            hsh_q    <= 1'b0;
            vsh_q    <= 1'b0;
            rot_q    <= '0;
            mir_q    <= '0;
            for (int i = 0; i < NSTEP; i++) res_q[i] <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        stride_q <= frm_stride;
                        width_q  <= frm_width;
                        height_q <= frm_height;
                        x_q      <= crop_x;
                        y_q      <= crop_y;
                        w_q      <= crop_w;
                        h_q      <= crop_h;
                        pdiv_q   <= plane_div;
                        hsh_q    <= chroma_hshift;
                        vsh_q    <= chroma_vshift;
                        rot_q    <= rot_code;
                        mir_q    <= mirror;
                        step_q   <= '0;
                        state_q  <= ST_ISSUE;
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (unit_done) begin
                        res_q[step_q] <= unit_res;
                        if (step_q == STEP_W'(NSTEP - 1)) begin
                            state_q <= ST_FINAL;
                        end else begin
                            step_q  <= step_q + 1'b1;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                default: begin
                    luma_off <= tl_y + add_y;
                    cb_off   <= tl_u + add_c;
                    cr_off   <= tl_v + add_c;
                    done     <= 1'b1;
                    state_q  <= ST_IDLE;
                end
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);

    // Completion is a single-cycle pulse.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Offsets hold their value outside the completion cycle.
    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(luma_off) && $stable(cb_off) && $stable(cr_off)));

    // A start during a running request leaves the captured crop untouched.
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> ($stable(x_q) && $stable(y_q) && $stable(rot_q)
                             && $stable(mir_q)));

    // Completion follows a running request.
    p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
endmodule

// File: tb/frame_corner_addr_test.sv
module frame_corner_addr_test;
    localparam int DIM_W = 16;
    localparam int OFF_W = 32;
    localparam int PDIV_W = 4;

    typedef struct {
        logic [31:0] y;
        logic [31:0] u;
        logic [31:0] v;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [DIM_W-1:0] frm_stride = '0, frm_width = '0, frm_height = '0;
    logic chroma_hshift = 1'b0, chroma_vshift = 1'b0;
    logic [PDIV_W-1:0] plane_div = '0;
    logic [DIM_W-1:0] crop_x = '0, crop_y = '0, crop_w = '0, crop_h = '0;
    logic [1:0] rot_code = '0, mirror = '0;
    logic busy, done;
    logic [OFF_W-1:0] luma_off, cb_off, cr_off;

    int checks = 0;
    int fails = 0;
    exp_t expq[$];

    always #4 clk = ~clk;  // 125 MHz

    frame_corner_addr #(.DIM_W(DIM_W), .OFF_W(OFF_W), .PDIV_W(PDIV_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .frm_stride(frm_stride), .frm_width(frm_width), .frm_height(frm_height),
        .chroma_hshift(chroma_hshift), .chroma_vshift(chroma_vshift),
        .plane_div(plane_div), .crop_x(crop_x), .crop_y(crop_y),
        .crop_w(crop_w), .crop_h(crop_h), .rot_code(rot_code), .mirror(mirror),
        .busy(busy), .done(done),
        .luma_off(luma_off), .cb_off(cb_off), .cr_off(cr_off)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Start corner table for R7, as {bottom,right}: TL=0, TR=1, BL=2, BR=3.
    function automatic logic [1:0] ref_corner(input logic [1:0] r,
                                              input logic [1:0] m);
        case ({r, m})
            4'h0: return 2'd0; 4'h1: return 2'd1; 4'h2: return 2'd2; 4'h3: return 2'd3;
            4'h4: return 2'd1; 4'h5: return 2'd0; 4'h6: return 2'd3; 4'h7: return 2'd2;
            4'h8: return 2'd3; 4'h9: return 2'd2; 4'hA: return 2'd1; 4'hB: return 2'd0;
            4'hC: return 2'd2; 4'hD: return 2'd3; 4'hE: return 2'd0; default: return 2'd1;
        endcase
    endfunction

    // Expected offsets from R2..R7.
    function automatic exp_t model(input int unsigned st, wd, ht, hs, vs, pd,
                                   x, y, w, h, input logic [1:0] r, m,
                                   input string tag);
        exp_t e;
        int unsigned bpp, cs, area, ly, lu, lv;
        logic [1:0] c;
        bpp  = st / wd;
        cs   = st >> hs;
        area = wd * ht;
        ly   = y * st + x * bpp;
        lu   = area + (y >> vs) * cs + (x >> hs);
        lv   = lu + area / pd;
        c    = ref_corner(r, m);
        if (c[1]) begin
            ly += (h - 1) * st;
            lu += ((h >> vs) - 1) * cs;
            lv += ((h >> vs) - 1) * cs;
        end
        if (c[0]) begin
            ly += (w - 1) * bpp;
            lu += (w >> hs) - 1;
            lv += (w >> hs) - 1;
        end
        e.y = ly; e.u = lu; e.v = lv; e.tag = tag;
        return e;
    endfunction

    task automatic drive(input int unsigned st, wd, ht, hs, vs, pd,
                         x, y, w, h, input logic [1:0] r, m);
        frm_stride = DIM_W'(st); frm_width = DIM_W'(wd); frm_height = DIM_W'(ht);
        chroma_hshift = hs[0]; chroma_vshift = vs[0]; plane_div = PDIV_W'(pd);
        crop_x = DIM_W'(x); crop_y = DIM_W'(y); crop_w = DIM_W'(w); crop_h = DIM_W'(h);
        rot_code = r; mirror = m;
    endtask

    // Driver: push the expectation, pulse start, wait for the scoreboard.
    task automatic run_job(input int unsigned st, wd, ht, hs, vs, pd,
                           x, y, w, h, input logic [1:0] r, m, input string tag);
        @(negedge clk);
        drive(st, wd, ht, hs, vs, pd, x, y, w, h, r, m);
        expq.push_back(model(st, wd, ht, hs, vs, pd, x, y, w, h, r, m, tag));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (expq.size() != 0) @(negedge clk);
    endtask

    // Monitor: compare each completion against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (expq.size() == 0) begin
                check("R8 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check({e.tag, " luma"}, luma_off, e.y);
                check({e.tag, " cb"}, cb_off, e.u);
                check({e.tag, " cr"}, cr_off, e.v);
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] hy;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", 32'(busy), 0);
        check("R1 done", 32'(done), 0);
        check("R1 luma", luma_off, 0);
        check("R1 cb", cb_off, 0);
        check("R1 cr", cr_off, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 R4 R5 R6 R7: every rotation/mirror pair on a 4:2:0 frame
        for (int r = 0; r < 4; r++) begin
            for (int m = 0; m < 4; m++) begin
                run_job(64, 64, 48, 1, 1, 4, 6, 10, 20, 12, 2'(r), 2'(m), "R7 table");
            end
        end
        // R2: bytes per pixel > 1, R3: horizontal-only subsampling, R4: factor 2
        run_job(256, 64, 30, 1, 0, 2, 3, 5, 17, 9, 2'd0, 2'd0, "R2 R3 R4 top-left");
        run_job(256, 64, 30, 1, 0, 2, 3, 5, 17, 9, 2'd2, 2'd0, "R5 R6 bottom-right");
        // R3: odd x and y with both shifts; R4: truncated plane quotient
        run_job(100, 50, 7, 1, 1, 3, 7, 9, 5, 5, 2'd1, 2'd1, "R3 R4 odd");
        // R5: h=1 with vertical shift wraps the chroma term modulo 2^32
        run_job(32, 32, 16, 0, 1, 1, 0, 0, 4, 1, 2'd3, 2'd0, "R5 wrap");
        // R6: w=1 with horizontal shift wraps the chroma term
        run_job(32, 32, 16, 1, 0, 4, 2, 2, 1, 3, 2'd0, 2'd1, "R6 wrap");

        // R8: done is one cycle and outputs hold afterwards
        check("R8 done low after pulse", 32'(done), 0);
        hy = luma_off;
        repeat (20) @(negedge clk);
        check("R8 luma holds", luma_off, hy);
        check("R8 done stays low", 32'(done), 0);

        // R9: a start during busy is ignored
        @(negedge clk);
        drive(64, 64, 48, 1, 1, 4, 6, 10, 20, 12, 2'd2, 2'd3);
        expq.push_back(model(64, 64, 48, 1, 1, 4, 6, 10, 20, 12, 2'd2, 2'd3, "R9 ignore"));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        check("R9 busy", 32'(busy), 1);
        drive(128, 32, 40, 0, 0, 1, 30, 20, 8, 8, 2'd1, 2'd2);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (expq.size() != 0) @(negedge clk);
        repeat (400) @(negedge clk);
        check("R9 no second done", 32'(expq.size()), 0);
        check("R9 idle", 32'(busy), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule